// File: doc/BRIEF.md
# Receive-side credit return encoder

This block lives on the receiving end of a credit-based packet link. It tracks how many buffer entries are free in each of six receive buffer classes: the command and data buffers of the posted-request, non-posted-request and response channels. Each class counts credits that the receiver owes the link partner. A counter starts at its buffer depth and grows by one whenever the buffer logic pulses that class's free input.

When the link has nothing else to send, the block offers a NOP. The NOP carries one 2-bit update field per class, and each field holds up to three credits. When the link accepts the NOP, each counter drops by exactly the amount its field reported. A count above three, such as the initial depth of a deep buffer, is therefore returned over several NOPs. The depth of each class is a separate parameter, and each counter is only as wide as its depth needs.

Top module: `rx_credit_return`

## Requirements
- R1: After reset, each class counter holds its configured depth, each field shows min(depth, 3), and `nop_pending_o` is 1.
- R2: The field of class i sits at `upd_o[2i+1:2i]`. The class indices are 0 posted command, 1 posted data, 2 non-posted command, 3 non-posted data, 4 response command, 5 response data.
- R3: At all times, each field equals min(counter, 3) for its class.
- R4: In a cycle where `nop_valid_o` and `nop_ready_i` are both high, each counter is reduced by the field value it shows in that cycle.
- R5: A free pulse adds one to its counter at the next edge. This holds even in a cycle where the same counter is being reduced by an accepted NOP, so no credit is lost.
- R6: `nop_valid_o` is high exactly when `link_idle_i` is high and `nop_pending_o` is high. Without an accept, the counters change only through free pulses.
- R7: `nop_pending_o` is high exactly when at least one counter is non-zero.
- R8: A counter above 3 is drained over successive accepted NOPs in steps of 3, followed by the remainder. For example, a depth of 8 is returned as 3, 3, 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| free_i | input | 6 | One-cycle per-class pulse: a buffer entry became free |
| link_idle_i | input | 1 | Link has no other packet to send |
| nop_ready_i | input | 1 | Link accepts the offered NOP this cycle |
| nop_valid_o | output | 1 | NOP with credit updates is offered |
| upd_o | output | 12 | Six 2-bit credit update fields, class i at bits 2i+1:2i |
| nop_pending_o | output | 1 | Some class still has credits to return |

## Verification
A wrong counter value shows up at `upd_o` in the same cycle whenever the true count is 3 or less. If the count is higher, the error stays hidden behind the saturated field until enough NOPs have drained it, and then shows as a wrong remainder or a wrong `nop_pending_o`. A lost or double-counted credit on a cycle where a free pulse coincides with an accept therefore appears at most a few accepted NOPs later. The bench runs a drain to zero after its random phase so that any residue becomes visible.

// File: rtl/rx_credit_pkg.sv
package rx_credit_pkg;
   localparam int unsigned NCLS      = 6;
   localparam int unsigned FIELD_W   = 2;
   localparam int unsigned FIELD_MAX = (1 << FIELD_W) - 1;
   localparam int unsigned UPD_W     = NCLS * FIELD_W;

   typedef enum logic [2:0] {
      CLS_POST_CMD  = 3'd0,
      CLS_POST_DAT  = 3'd1,
      CLS_NPOST_CMD = 3'd2,
      CLS_NPOST_DAT = 3'd3,
      CLS_RSP_CMD   = 3'd4,
      CLS_RSP_DAT   = 3'd5
   } cls_e;
endpackage

// File: rtl/rx_credit_ctr.sv
module rx_credit_ctr
   import rx_credit_pkg::*;
#(
   parameter int unsigned DEPTH = 4
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               free_i,
   input  logic               take_i,
   output logic [FIELD_W-1:0] field_o,
   output logic               nz_o
);
   localparam int unsigned W  = $clog2(DEPTH + 1);
   localparam int unsigned XW = W + FIELD_W;

   if (DEPTH < 1) begin : g_bad_depth
      $error("rx_credit_ctr: DEPTH must be at least 1");
   end

   logic [W-1:0]  cnt;
   logic [XW-1:0] cnt_x;
   logic [XW-1:0] cnt_nx;

   assign cnt_x = XW'(cnt);

   if (DEPTH <= FIELD_MAX) begin : g_fits
      // whole count always fits in one field
      assign field_o = FIELD_W'(cnt_x);
   end else begin : g_sat
      assign field_o = (cnt_x >= XW'(FIELD_MAX)) ? FIELD_W'(FIELD_MAX)
                                                 : FIELD_W'(cnt_x);
   end

   assign nz_o = (cnt != '0);

   always_comb begin
      cnt_nx = cnt_x + XW'(free_i);
      if (take_i) cnt_nx = cnt_nx - XW'(field_o);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= W'(DEPTH);
      else        cnt <= cnt_nx[W-1:0];
   end

   // R5
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= W'(DEPTH));

   // R5
   free_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (free_i && !take_i && cnt < W'(DEPTH)) |=> (cnt == $past(cnt) + 1'b1));

   // R4
   small_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && !free_i && cnt_x <= XW'(FIELD_MAX)) |=> (cnt == '0));
endmodule

// File: rtl/rx_nop_pack.sv
module rx_nop_pack
   import rx_credit_pkg::*;
(
   input  logic [UPD_W-1:0] fld_i,
   input  logic [NCLS-1:0]  nz_i,
   input  logic             link_idle_i,
   input  logic             nop_ready_i,
   output logic [UPD_W-1:0] upd_o,
   output logic             nop_valid_o,
   output logic             nop_pending_o,
   output logic             take_o
);
   assign nop_pending_o = |nz_i;
   assign nop_valid_o   = link_idle_i & nop_pending_o;
   assign take_o        = nop_valid_o & nop_ready_i;
   assign upd_o         = fld_i;
endmodule

// File: rtl/rx_credit_return.sv
module rx_credit_return
   import rx_credit_pkg::*;
#(
   parameter int unsigned CLASS_DEPTH [NCLS] = '{5, 2, 4, 1, 8, 3}
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NCLS-1:0]  free_i,
   input  logic             link_idle_i,
   input  logic             nop_ready_i,
   output logic             nop_valid_o,
   output logic [UPD_W-1:0] upd_o,
   output logic             nop_pending_o
);
   logic [UPD_W-1:0] fld;
   logic [NCLS-1:0]  nz;
   logic             take;

   for (genvar g = 0; g < NCLS; g++) begin : g_cls
      rx_credit_ctr #(.DEPTH(CLASS_DEPTH[g])) u_ctr (
         .clk     (clk),
         .rst_n   (rst_n),
         .free_i  (free_i[g]),
         .take_i  (take),
         .field_o (fld[g*FIELD_W +: FIELD_W]),
         .nz_o    (nz[g])
      );
   end

   rx_nop_pack u_pack (
      .fld_i         (fld),
      .nz_i          (nz),
      .link_idle_i   (link_idle_i),
      .nop_ready_i   (nop_ready_i),
      .upd_o         (upd_o),
      .nop_valid_o   (nop_valid_o),
      .nop_pending_o (nop_pending_o),
      .take_o        (take)
   );

   // R6
   valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nop_valid_o |-> (link_idle_i && nop_pending_o));

   // R7
   quiet_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !nop_pending_o |-> (upd_o == '0));

   // R6
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!link_idle_i && free_i == '0) |=> $stable(upd_o));
endmodule

// File: tb/rx_credit_return_tb.sv
module rx_credit_return_tb;
   localparam int NC = 6;
   localparam int DEP [NC] = '{5, 2, 4, 1, 8, 3};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NC-1:0] free_i = '0;
   logic          link_idle_i = 1'b0;
   logic          nop_ready_i = 1'b0;
   logic          nop_valid_o;
   logic [11:0]   upd_o;
   logic          nop_pending_o;

   int checks = 0;
   int errors = 0;
   int mcnt [NC];
   string tag = "R1";

   always #2.5 clk = ~clk;

   rx_credit_return #(.CLASS_DEPTH('{5, 2, 4, 1, 8, 3})) u_dut (
      .clk(clk), .rst_n(rst_n), .free_i(free_i),
      .link_idle_i(link_idle_i), .nop_ready_i(nop_ready_i),
      .nop_valid_o(nop_valid_o), .upd_o(upd_o), .nop_pending_o(nop_pending_o)
   );

   function automatic int fmin(int c);
      return (c > 3) ? 3 : c;
   endfunction

   function automatic bit any_nz();
      for (int i = 0; i < NC; i++) if (mcnt[i] != 0) return 1'b1;
      return 1'b0;
   endfunction

   // R2 R3: field i at upd_o[2i+1:2i] = min(count,3); R6 valid; R7 pending
   task automatic compare();
      for (int i = 0; i < NC; i++) begin
         checks++;
         if (int'(upd_o[2*i +: 2]) != fmin(mcnt[i])) begin
            errors++;
            $display("FAIL %s R3 field class %0d: actual %0d expected %0d",
                     tag, i, upd_o[2*i +: 2], fmin(mcnt[i]));
         end
      end
      checks++;
      if (nop_pending_o != any_nz()) begin
         errors++;
         $display("FAIL %s R7 pending: actual %0b expected %0b", tag, nop_pending_o, any_nz());
      end
      checks++;
      if (nop_valid_o != (link_idle_i && any_nz())) begin
         errors++;
         $display("FAIL %s R6 valid: actual %0b expected %0b", tag, nop_valid_o,
                  link_idle_i && any_nz());
      end
   endtask

   // R4 R5: model of the next edge for the inputs now applied
   task automatic step(input logic [NC-1:0] fr, input logic idle, input logic rdy);
      bit acc;
      free_i = fr; link_idle_i = idle; nop_ready_i = rdy;
      acc = idle && rdy && any_nz();
      for (int i = 0; i < NC; i++)
         mcnt[i] = mcnt[i] - (acc ? fmin(mcnt[i]) : 0) + int'(fr[i]);
      @(negedge clk);
      compare();
   endtask

   initial begin
      for (int i = 0; i < NC; i++) mcnt[i] = DEP[i];
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      tag = "R1";
      compare();

      tag = "R6";
      repeat (3) step('0, 1'b0, 1'b1);
      repeat (2) step('0, 1'b1, 1'b0);

      // R8: class 4 depth 8 drains 3,3,2
      tag = "R8";
      checks++;
      if (upd_o[9:8] != 2'd3) begin
         errors++;
         $display("FAIL R8 first step: actual %0d expected 3", upd_o[9:8]);
      end
      step('0, 1'b1, 1'b1);
      step('0, 1'b1, 1'b1);
      checks++;
      if (upd_o[9:8] != 2'd2) begin
         errors++;
         $display("FAIL R8 last step: actual %0d expected 2", upd_o[9:8]);
      end
      tag = "R4";
      step('0, 1'b1, 1'b1);
      repeat (2) step('0, 1'b1, 1'b1);

      tag = "R5";
      step('1, 1'b0, 1'b0);
      step('1, 1'b1, 1'b1);
      step('0, 1'b1, 1'b1);

      tag = "R3";
      for (int k = 0; k < 3000; k++) begin
         logic [NC-1:0] fr;
         for (int i = 0; i < NC; i++)
            fr[i] = (mcnt[i] < DEP[i]) && ($urandom_range(0, 2) == 0);
         step(fr, ($urandom_range(0, 3) != 0), ($urandom_range(0, 2) != 0));
      end

      tag = "R7";
      for (int k = 0; k < 10; k++) step('0, 1'b1, 1'b1);
      checks++;
      if (nop_pending_o !== 1'b0) begin
         errors++;
         $display("FAIL R7 final drain: actual %0b expected 0", nop_pending_o);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog expired: actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule